// File: doc/BRIEF.md
# Flash memory-map read sequencer

This block makes the contents of a serial NOR flash look like ordinary read-only memory. A read request on the bus side carries a byte offset. The sequencer then pulls chip select low under its own control and clocks out an optional command byte. It follows that with a 3- or 4-byte address, most significant byte first, and then runs a programmable number of dummy clocks. Last, it gathers `BYTES` data bytes over one, two or four data lines. Once chip select is released, it presents the bytes on the bus together with a single-cycle ready strobe.

The shape of every sequence is taken from a transfer control word, `tran_csr`, which is supplied from elsewhere. The command byte is derived from that word and is not programmed directly. The word gives the data-line count, the fast-read form, the choice of the 4-byte-address command variant and the address length. The serial clock divider and the clock polarity and phase are shared with the FIFO transfer engine, which sits outside this block. A one-bit memory-map enable wakes up set, so that boot code can fetch from flash with no setup. It is cleared or set by a write strobe.

The controller runs through these states: IDLE (waiting), SETUP (chip select low, clock idle, one half period), CMD (8 command bits), ADDR (24 or 32 address bits), DUMMY (turnaround clocks), DATA (read bits), RELEASE (chip select high, one half period) and DONE (ready strobe). The transitions are: IDLE→SETUP when a request is accepted; SETUP→CMD, or SETUP→ADDR when there is no command byte; CMD→ADDR; ADDR→DUMMY, or ADDR→DATA when the dummy count is zero; DUMMY→DATA; DATA→RELEASE; RELEASE→DONE; DONE→IDLE.

Top module: `flash_mmap_reader`

## Requirements
- R1: The memory-map enable is 1 after reset. A cycle with `mm_wr`=1 loads it from `mm_wdata`. While it is 0, a pending request starts no sequence: `spi_cs_n` stays high and `bus_ready` stays low. The request starts once the enable returns to 1.
- R2: A request is accepted only while `cs_ctrl` is 0 (hardware chip-select control). With any other value it waits, and `spi_cs_n` does not fall.
- R3: The command byte is chosen from `tran_csr`. Bit 5 selects quad (0x6B), else bit 4 selects dual (0x3B), else bit 3 selects fast (0x0B), else normal (0x03). When bit 21 is set, the 4-byte-address variants 0x6C, 0x3C, 0x0C and 0x13 replace them.
- R4: A command byte is sent only when `tran_csr` bit 11 is 1. It goes out MSB first on `spi_io_out[0]`, with `spi_io_oe` = 4'b0001.
- R5: The address is 4 bytes when `tran_csr[10:8]` = 4 and bit 20 is 1, and 3 bytes (the low 24 bits of `bus_addr`) otherwise. It goes out MSB first on `spi_io_out[0]`.
- R6: After the address, exactly `tran_csr[19:16]` dummy clock cycles run with all `spi_io_oe` bits 0.
- R7: The data phase uses the selected width; command and address always use a single line. In single mode one bit per clock comes from `spi_io_in[1]`. In dual mode two bits come per clock, with `spi_io_in[1]` carrying the higher bit. In quad mode a nibble comes per clock on `spi_io_in[3:0]`. Each byte arrives MSB first.
- R8: `bus_rdata[8*i+7:8*i]` holds the flash byte at address offset+i, for i from 0 to `BYTES`-1.
- R9: `spi_cs_n` rises after the last data clock. `bus_ready` is then high for exactly one cycle, and `spi_cs_n` is already high in that cycle.
- R10: `spi_sck` rests at `cpol`, and each half period lasts `sck_div`+1 clocks. Data is sampled on the leading edge when `cpha`=0 and on the trailing edge when `cpha`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mm_wr | input | 1 | Write strobe for the memory-map enable |
| mm_wdata | input | 1 | New enable value |
| tran_csr | input | 22 | Transfer control word |
| cs_ctrl | input | 2 | Chip-select control setting; 0 means hardware control |
| sck_div | input | DIV_W | Serial clock divider |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase |
| bus_req | input | 1 | Read request, held until ready |
| bus_addr | input | ADDR_W | Byte offset into the flash |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 8*BYTES | Read data, lowest address in the low byte |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_io_out | output | 4 | Data lines driven out |
| spi_io_oe | output | 4 | Output enables for the data lines |
| spi_io_in | input | 4 | Data lines sampled in |

## Verification
A table of control words sweeps every command-byte choice. It covers normal, fast, dual and quad reads, each with and without the 4-byte variant, and a read with no command byte. One word sets all three width bits to expose the priority order. Another sets address length 4 without the 4-byte enable, to show that 3-byte truncation wins. Dummy counts of 0, 2, 6 and 8, all four clock modes and dividers of 0 to 2 are spread across the vectors. A bench flash model decodes the serial stream and returns address-dependent bytes. A wrong command byte, address byte order, width mapping, byte lane order or edge choice therefore shows up as a distinct mismatch. Directed cases hold a request while the enable is cleared and while software chip-select control is set.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    localparam int CSR_W        = 22;
    localparam int B_FAST       = 3;
    localparam int B_DUAL       = 4;
    localparam int B_QUAD       = 5;
    localparam int B_ALEN_LSB   = 8;
    localparam int B_WITH_CMD   = 11;
    localparam int B_DUM_LSB    = 16;
    localparam int B_A4_EN      = 20;
    localparam int B_OP4        = 21;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_RELEASE,
        ST_DONE
    } fsq_state_e;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0,
        LANE_X2 = 2'd1,
        LANE_X4 = 2'd2
    } lane_e;

    typedef struct packed {
        logic [7:0] opcode;
        logic       with_cmd;
        logic       addr4;
        logic [3:0] dummy;
        lane_e      lanes;
    } rd_cfg_t;

endpackage

// File: rtl/fsq_cfg_decode.sv
module fsq_cfg_decode
    import fsq_pkg::*;
(
    input  logic [CSR_W-1:0] csr,
    output rd_cfg_t          cfg
);

    logic [7:0] op3;
    logic [7:0] op4;
    logic       unused_csr_bits;

    assign unused_csr_bits = ^{csr[2:0], csr[7:6], csr[15:12]};

    // R3: width bits pick the family with quad over dual over fast
    always_comb begin
        cfg.with_cmd = csr[B_WITH_CMD];
        cfg.addr4    = (csr[B_ALEN_LSB+2:B_ALEN_LSB] == 3'd4) && csr[B_A4_EN];
        cfg.dummy    = csr[B_DUM_LSB+3:B_DUM_LSB];
        if (csr[B_QUAD]) begin
            cfg.lanes = LANE_X4;
            op3       = 8'h6B;
            op4       = 8'h6C;
        end else if (csr[B_DUAL]) begin
            cfg.lanes = LANE_X2;
            op3       = 8'h3B;
            op4       = 8'h3C;
        end else if (csr[B_FAST]) begin
            cfg.lanes = LANE_X1;
            op3       = 8'h0B;
            op4       = 8'h0C;
        end else begin
            cfg.lanes = LANE_X1;
            op3       = 8'h03;
            op4       = 8'h13;
        end
        cfg.opcode = csr[B_OP4] ? op4 : op3;
    end

endmodule

// File: rtl/fsq_half_timer.sv
module fsq_half_timer #(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // R10: one tick every div+1 clocks while running
    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fsq_rx_gather.sv
module fsq_rx_gather
    import fsq_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  lane_e              lanes,
    input  logic [3:0]         io_in,
    output logic [8*BYTES-1:0] word
);

    localparam int RW = 8 * BYTES;

    logic [RW-1:0] rx;

    // R7: bits per clock follow the lane count, MSB of each byte first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx <= '0;
        end else if (clr) begin
            rx <= '0;
        end else if (shift) begin
            unique case (lanes)
                LANE_X1: rx <= {rx[RW-2:0], io_in[1]};
                LANE_X2: rx <= {rx[RW-3:0], io_in[1:0]};
                LANE_X4: rx <= {rx[RW-5:0], io_in};
                default: rx <= rx;
            endcase
        end
    end

    // R8: the first byte received lands in the lowest lane
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign word[8*i +: 8] = rx[8*(BYTES-1-i) +: 8];
    end

endmodule

// File: rtl/flash_mmap_reader.sv
module flash_mmap_reader
    import fsq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BYTES  = 4,
    parameter int DIV_W  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mm_wr,
    input  logic               mm_wdata,
    input  logic [CSR_W-1:0]   tran_csr,
    input  logic [1:0]         cs_ctrl,
    input  logic [DIV_W-1:0]   sck_div,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               bus_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               bus_ready,
    output logic [8*BYTES-1:0] bus_rdata,
    output logic               spi_sck,
    output logic               spi_cs_n,
    output logic [3:0]         spi_io_out,
    output logic [3:0]         spi_io_oe,
    input  logic [3:0]         spi_io_in
);

    localparam int DATA_BITS = 8 * BYTES;
    localparam int MAX_BITS  = (DATA_BITS > 32) ? DATA_BITS : 32;
    localparam int CNT_W     = $clog2(MAX_BITS + 1);
    localparam int TX_W      = 40;

    fsq_state_e       state, state_nx;
    rd_cfg_t          cfg_d, cfg_q;
    logic             mm_en;
    logic             half;
    logic [CNT_W-1:0] bitcnt, last_idx;
    logic [TX_W-1:0]  tx, tx_load;
    logic [31:0]      addr32, addr_field;
    logic             cs_n_q;
    logic             tick, run, in_bits, start, bit_end, phase_done;

    fsq_cfg_decode u_decode (
        .csr (tran_csr),
        .cfg (cfg_d)
    );

    fsq_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (sck_div),
        .tick  (tick)
    );

    fsq_rx_gather #(.BYTES(BYTES)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .shift (state == ST_DATA && tick && !half),
        .lanes (cfg_q.lanes),
        .io_in (spi_io_in),
        .word  (bus_rdata)
    );

    // R1: memory-map enable wakes up set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mm_en <= 1'b1;
        end else if (mm_wr) begin
            mm_en <= mm_wdata;
        end
    end

    // R1, R2: accept only when enabled and under hardware chip select
    assign start   = (state == ST_IDLE) && bus_req && mm_en && (cs_ctrl == 2'b00);
    assign in_bits = state inside {ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA};
    assign run     = !(state inside {ST_IDLE, ST_DONE});
    assign bit_end = in_bits && tick && half;

    always_comb begin
        unique case (state)
            ST_CMD:   last_idx = CNT_W'(7);
            ST_ADDR:  last_idx = cfg_q.addr4 ? CNT_W'(31) : CNT_W'(23);
            ST_DUMMY: last_idx = CNT_W'(cfg_q.dummy) - CNT_W'(1);
            ST_DATA:  last_idx = CNT_W'((DATA_BITS >> cfg_q.lanes) - 1);
            default:  last_idx = '0;
        endcase
    end

    assign phase_done = bit_end && (bitcnt == last_idx);

    // R4, R5: command byte then address, MSB aligned in the shifter
    assign addr32     = 32'(bus_addr);
    assign addr_field = cfg_d.addr4 ? addr32 : {addr32[23:0], 8'h00};
    assign tx_load    = cfg_d.with_cmd ? {cfg_d.opcode, addr_field} : {addr_field, 8'h00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_SETUP;
            ST_SETUP:   if (tick) state_nx = cfg_q.with_cmd ? ST_CMD : ST_ADDR;
            ST_CMD:     if (phase_done) state_nx = ST_ADDR;
            ST_ADDR:    if (phase_done) state_nx = (cfg_q.dummy != 4'd0) ? ST_DUMMY : ST_DATA;
            ST_DUMMY:   if (phase_done) state_nx = ST_DATA;
            ST_DATA:    if (phase_done) state_nx = ST_RELEASE;
            ST_RELEASE: if (tick) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            tx     <= '0;
            half   <= 1'b0;
            bitcnt <= '0;
            cs_n_q <= 1'b1;
        end else if (start) begin
            cfg_q  <= cfg_d;
            tx     <= tx_load;
            half   <= 1'b0;
            bitcnt <= '0;
            cs_n_q <= 1'b0;
        end else if (in_bits && tick) begin
            if (!half) begin
                half <= 1'b1;
            end else begin
                half   <= 1'b0;
                bitcnt <= (bitcnt == last_idx) ? '0 : bitcnt + 1'b1;
                if (state == ST_CMD || state == ST_ADDR) begin
                    tx <= {tx[TX_W-2:0], 1'b0};
                end
                // R9: release chip select right after the last data clock
                if (state == ST_DATA && bitcnt == last_idx) begin
                    cs_n_q <= 1'b1;
                end
            end
        end
    end

    // Outputs. R10: the first half of every bit holds cpol^cpha, the second its inverse
    always_comb begin
        spi_cs_n   = cs_n_q;
        spi_sck    = in_bits ? (half ? (cpol ^ ~cpha) : (cpol ^ cpha)) : cpol;
        spi_io_out = {3'b000, tx[TX_W-1]};
        spi_io_oe  = (state == ST_CMD || state == ST_ADDR) ? 4'b0001 : 4'b0000;
        bus_ready  = (state == ST_DONE);
    end

    AST_READY_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> spi_cs_n); // R9
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready); // R9
    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !mm_en) |=> (state == ST_IDLE)); // R1
    AST_SOFT_CS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cs_ctrl != 2'b00) |=> spi_cs_n); // R2
    AST_DRIVE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_io_oe != 4'b0000) |-> !spi_cs_n); // R4
    AST_DUMMY_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY) |-> (spi_io_oe == 4'b0000)); // R6
    AST_SCK_REST_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sck == cpol)); // R10

endmodule

// File: tb/test_flash_mmap_reader.sv
module test_flash_mmap_reader;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mm_wr, mm_wdata;
    logic [21:0] tran_csr;
    logic [1:0]  cs_ctrl;
    logic [10:0] sck_div;
    logic        cpol, cpha;
    logic        bus_req;
    logic [31:0] bus_addr;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_cs_n;
    logic [3:0]  spi_io_out, spi_io_oe;
    logic [3:0]  io_in = 4'h0;

    always #4 clk = ~clk;

    flash_mmap_reader i_flash_mmap_reader (
        .clk(clk), .rst_n(rst_n), .mm_wr(mm_wr), .mm_wdata(mm_wdata),
        .tran_csr(tran_csr), .cs_ctrl(cs_ctrl), .sck_div(sck_div),
        .cpol(cpol), .cpha(cpha), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
        .spi_io_in(io_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fmem(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // flash model state
    bit          m_cpol, m_cpha;
    int          m_hbits, m_abits, m_hb, m_wl;
    int          m_cnt, m_last_cnt, cs_falls, act_cnt;
    logic [63:0] m_hdr;

    always @(negedge spi_cs_n) begin
        m_cnt = 0;
        m_hdr = '0;
        cs_falls++;
    end

    always @(posedge spi_cs_n) m_last_cnt = m_cnt;

    always @(posedge spi_sck or negedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            bit lead;
            lead = (spi_sck != m_cpol);
            if (lead ^ m_cpha) begin
                if (m_cnt < m_hbits) m_hdr = {m_hdr[62:0], spi_io_out[0]};
                m_cnt++;
            end else if (m_cnt >= m_hb) begin
                int w, bp, off;
                logic [31:0] a;
                logic [7:0]  b;
                w   = 1 << m_wl;
                bp  = (m_cnt - m_hb) * w;
                off = bp % 8;
                a   = (m_abits == 32) ? m_hdr[31:0] : {8'h00, m_hdr[23:0]};
                b   = fmem(a + 32'(bp / 8));
                for (int j = 0; j < w; j++) begin
                    io_in[(w == 1) ? 1 : (w - 1 - j)] = b[7 - off - j];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (spi_cs_n === 1'b0 && spi_sck != cpol) act_cnt++;
    end

    localparam int NV = 10;
    localparam logic [31:0] V_CSR   [NV] = '{32'h000B00, 32'h080B08, 32'h080B10, 32'h080B20, 32'h300C00,
                                             32'h360C20, 32'h380C08, 32'h200C10, 32'h000300, 32'h020B38};
    localparam logic [31:0] V_ADDR  [NV] = '{32'h00012345, 32'h00ABCDE0, 32'h00100000, 32'h00000102, 32'h01ABCDEF,
                                             32'h02000010, 32'h7FFFFFF0, 32'h05FFFFFC, 32'h00000400, 32'h00003456};
    localparam logic [31:0] V_EADDR [NV] = '{32'h00012345, 32'h00ABCDE0, 32'h00100000, 32'h00000102, 32'h01ABCDEF,
                                             32'h02000010, 32'h7FFFFFF0, 32'h00FFFFFC, 32'h00000400, 32'h00003456};
    localparam int V_DIV  [NV] = '{0, 1, 2, 0, 0, 1, 0, 0, 0, 1};
    localparam int V_CPOL [NV] = '{0, 1, 0, 1, 0, 0, 1, 0, 0, 1};
    localparam int V_CPHA [NV] = '{0, 1, 1, 0, 0, 0, 1, 0, 0, 0};
    localparam logic [7:0] V_OP [NV] = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'h13, 8'h6C, 8'h0C, 8'h3C, 8'h00, 8'h6B};
    localparam int V_CMD  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 0, 1};
    localparam int V_AB   [NV] = '{3, 3, 3, 3, 4, 4, 4, 3, 3, 3};
    localparam int V_DUM  [NV] = '{0, 8, 8, 8, 0, 6, 8, 0, 0, 2};
    localparam int V_WL   [NV] = '{0, 0, 1, 2, 0, 2, 0, 1, 0, 2};

    task automatic setup_vec(input int v);
        @(negedge clk);
        tran_csr = V_CSR[v][21:0];
        sck_div  = 11'(V_DIV[v]);
        cpol     = V_CPOL[v][0];
        cpha     = V_CPHA[v][0];
        m_cpol   = V_CPOL[v][0];
        m_cpha   = V_CPHA[v][0];
        m_abits  = V_AB[v] * 8;
        m_hbits  = V_CMD[v] * 8 + m_abits;
        m_hb     = m_hbits + V_DUM[v];
        m_wl     = V_WL[v];
    endtask

    task automatic wait_ready(output logic [31:0] d, output bit ok, output bit csh);
        ok = 0;
        d = '0;
        csh = 0;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (bus_ready) begin
                ok = 1;
                d = bus_rdata;
                csh = spi_cs_n;
                break;
            end
        end
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = fmem(a + 32'(i));
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit ok, csh;
        int tot, rdy_seen;
        rst_n = 1'b0; mm_wr = 1'b0; mm_wdata = 1'b0; tran_csr = '0; cs_ctrl = 2'b00;
        sck_div = '0; cpol = 1'b0; cpha = 1'b0; bus_req = 1'b0; bus_addr = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // reset state (R1, R9, R10)
        check(spi_cs_n == 1'b1, "R9 cs_n high in reset", 64'(spi_cs_n), 1);
        check(bus_ready == 1'b0, "R9 no ready in reset", 64'(bus_ready), 0);
        check(spi_sck == 1'b0, "R10 sck rests at cpol", 64'(spi_sck), 0);
        check(spi_io_oe == 4'h0, "R4 no drive in reset", 64'(spi_io_oe), 0);
        rst_n = 1'b1;

        // vector table, first read relies on the enable's reset value (R1)
        for (int v = 0; v < NV; v++) begin
            setup_vec(v);
            act_cnt = 0;
            bus_req = 1'b1;
            bus_addr = V_ADDR[v];
            wait_ready(d, ok, csh);
            tot = V_CMD[v] * 8 + V_AB[v] * 8 + V_DUM[v] + (32 >> V_WL[v]);
            check(ok, "R1 read completes", 64'(ok), 1);
            if (V_CMD[v] == 1)
                check(m_hdr[m_abits +: 8] == V_OP[v], "R3 R4 command byte", 64'(m_hdr[m_abits +: 8]), 64'(V_OP[v]));
            check(((m_abits == 32) ? m_hdr[31:0] : {8'h00, m_hdr[23:0]}) == V_EADDR[v], "R5 address",
                  64'(m_hdr[31:0]), 64'(V_EADDR[v]));
            check(m_last_cnt == tot, "R4 R6 clock count", 64'(m_last_cnt), 64'(tot));
            check(d == exp_word(V_EADDR[v]), "R7 R8 data", 64'(d), 64'(exp_word(V_EADDR[v])));
            check(csh == 1'b1, "R9 cs_n high at ready", 64'(csh), 1);
            check(act_cnt == tot * (V_DIV[v] + 1), "R10 half period", 64'(act_cnt), 64'(tot * (V_DIV[v] + 1)));
            @(negedge clk);
            check(spi_sck == cpol, "R10 sck idle after read", 64'(spi_sck), 64'(cpol));
        end

        // R1: disabled enable holds the request off
        setup_vec(0);
        mm_wr = 1'b1; mm_wdata = 1'b0;
        @(negedge clk);
        mm_wr = 1'b0;
        cs_falls = 0; rdy_seen = 0;
        bus_req = 1'b1; bus_addr = 32'h00000777;
        repeat (300) begin
            @(negedge clk);
            if (bus_ready) rdy_seen++;
        end
        check(cs_falls == 0, "R1 no select while disabled", 64'(cs_falls), 0);
        check(rdy_seen == 0, "R1 no ready while disabled", 64'(rdy_seen), 0);
        mm_wr = 1'b1; mm_wdata = 1'b1;
        @(negedge clk);
        mm_wr = 1'b0;
        wait_ready(d, ok, csh);
        check(ok && d == exp_word(32'h00000777), "R1 read after re-enable", 64'(d), 64'(exp_word(32'h00000777)));

        // R2: software chip-select control blocks the sequence
        @(negedge clk);
        cs_ctrl = 2'b10;
        cs_falls = 0; rdy_seen = 0;
        bus_req = 1'b1; bus_addr = 32'h00001200;
        repeat (200) begin
            @(negedge clk);
            if (bus_ready) rdy_seen++;
        end
        check(cs_falls == 0 && rdy_seen == 0, "R2 no select under software control", 64'(cs_falls + rdy_seen), 0);
        cs_ctrl = 2'b00;
        wait_ready(d, ok, csh);
        check(ok && d == exp_word(32'h00001200), "R2 read after hardware control", 64'(d), 64'(exp_word(32'h00001200)));

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule